// File: doc/BRIEF.md
# Asynchronous SRAM access controller

This block connects a clocked request port to an external asynchronous static RAM of 512K bytes. The memory uses active-low select, output-enable and write-strobe lines. A client offers one access at a time with a valid/ready handshake. A read returns one byte with a one-cycle response strobe. The controller generates the memory strobes with enough clock cycles between edges to meet the part's access, pulse-width and setup times at the configured clock period.

Every wait length is derived at elaboration. Each timing figure, given in picoseconds, is divided by the clock period and rounded up, with a floor of one cycle. The data bus is split into an outgoing value, an incoming value and a drive enable, so that pad buffers can be added outside the block.

The controller also sequences the bus turnaround. Output enable stays high for the whole of a write. The controller starts driving the bus only after the memory's outputs have had time to float. It stops driving on the same edge that ends the write strobe.

Top module: `sram_access_ctrl`

## Requirements
- R1: After reset, `req_ready` stays low, all three strobes stay high and the bus is not driven for exactly ceil(T_PWRUP_PS/CLK_PS) rising edges. `req_ready` is high from the next sample onward.
- R2: `req_ready` is low in every cycle in which the memory is selected, so at most one access is in progress.
- R3: A read holds select and output enable low and the write strobe high for exactly ceil(T_AA_PS/CLK_PS) cycles.
- R4: A read returns the byte present on `mem_dq_in` in the last cycle of the read. The byte appears on `rsp_rdata` with `rsp_valid` high for one cycle, in the cycle in which select and output enable return high. That is ceil(T_AA_PS/CLK_PS) edges after the edge that accepts the request.
- R5: A write keeps output enable high. It lowers select with the address one cycle before the write strobe falls. It keeps the write strobe low for at least ceil(T_PWE_PS/CLK_PS) cycles.
- R6: During a write the controller drives the bus only after the write strobe has been low for ceil(T_HZWE_PS/CLK_PS) cycles. It stops driving on the edge where the write strobe rises.
- R7: The written byte is driven, unchanged, for at least ceil(T_SD_PS/CLK_PS) cycles before the write strobe rises. The byte stored is the request's write data.
- R8: Output enable and the write strobe are never low together. The controller never drives while the memory may drive.
- R9: The memory address is unchanged in every cycle while select stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request offered |
| req_ready | output | 1 | Controller can accept a request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | DATA_W | Byte to write |
| rsp_valid | output | 1 | One-cycle read data strobe |
| rsp_rdata | output | DATA_W | Read data |
| mem_ce_n | output | 1 | Memory select, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write strobe, active low |
| mem_addr | output | ADDR_W | Memory address bus |
| mem_dq_out | output | DATA_W | Data driven toward the memory |
| mem_dq_in | input | DATA_W | Data received from the memory |
| mem_dq_oe | output | 1 | Enable for the controller's bus drivers |

## Verification
The assertions assume a few things about the environment. A request is held only while `req_ready` is high. The memory's read data on `mem_dq_in` is valid from the first read cycle onward. Reset starts low, so the power-up window is measured from its release.

The bench memory model drives the bus only in the read combination of strobes, with no delay. It stores on the trailing edge of the select/strobe overlap. Requests are raised only when `req_ready` is seen high, and each is withdrawn after one accepting edge, so the assumed handshake is never broken.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_PWRUP,
        ST_IDLE,
        ST_READ,
        ST_WSET,
        ST_WTURN,
        ST_WDATA
    } seq_state_e;

    // timing in ps -> whole cycles, rounded up, never below one
    function automatic int unsigned ps_to_cyc(input int unsigned t_ps, input int unsigned clk_ps);
        int unsigned c;
        c = (t_ps + clk_ps - 1) / clk_ps;
        return (c == 0) ? 1 : c;
    endfunction

    function automatic int unsigned umax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_wait_timer.sv
module sram_wait_timer #(
    parameter int unsigned CW       = 8,
    parameter int unsigned RST_LOAD = 0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          last
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= CW'(RST_LOAD);
        else        cnt_q <= cnt_d;
    end

    assign last = (cnt_q == '0);
endmodule

// File: rtl/sram_rd_capture.sv
module sram_rd_capture #(
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cap_en,
    input  logic [DW-1:0] bus_in,
    output logic [DW-1:0] rdata,
    output logic          rvalid
);
    logic [DW-1:0] data_d, data_q;
    logic          vld_d, vld_q;

    always_comb begin
        vld_d  = cap_en;
        data_d = cap_en ? bus_in : data_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
            vld_q  <= 1'b0;
        end else begin
            data_q <= data_d;
            vld_q  <= vld_d;
        end
    end

    assign rdata  = data_q;
    assign rvalid = vld_q;
endmodule

// File: rtl/sram_access_ctrl.sv
module sram_access_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int unsigned ADDR_W     = 19,
    parameter int unsigned DATA_W     = 8,
    parameter int unsigned CLK_PS     = 5000,
    parameter int unsigned T_PWRUP_PS = 1000000,
    parameter int unsigned T_AA_PS    = 10000,
    parameter int unsigned T_PWE_PS   = 7000,
    parameter int unsigned T_SD_PS    = 5000,
    parameter int unsigned T_HZWE_PS  = 5000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_out,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic              mem_dq_oe
);
    localparam int unsigned PWR_CYC = ps_to_cyc(T_PWRUP_PS, CLK_PS);
    localparam int unsigned AA_CYC  = ps_to_cyc(T_AA_PS, CLK_PS);
    localparam int unsigned PWE_CYC = ps_to_cyc(T_PWE_PS, CLK_PS);
    localparam int unsigned SD_CYC  = ps_to_cyc(T_SD_PS, CLK_PS);
    localparam int unsigned HZ_CYC  = ps_to_cyc(T_HZWE_PS, CLK_PS);
    // driven phase must cover data setup and the rest of the strobe width
    localparam int unsigned REST_CYC = (PWE_CYC > HZ_CYC) ? (PWE_CYC - HZ_CYC) : 1;
    localparam int unsigned WD_CYC   = umax(SD_CYC, REST_CYC);
    localparam int unsigned MAX_CYC  = umax(umax(PWR_CYC, AA_CYC), umax(HZ_CYC, WD_CYC));
    localparam int unsigned CW       = $clog2(MAX_CYC + 1);

    typedef struct packed {
        seq_state_e        state;
        logic              ce_n;
        logic              oe_n;
        logic              we_n;
        logic              dq_oe;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } ctl_t;

    localparam ctl_t CTL_RST = '{
        state: ST_PWRUP, ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, dq_oe: 1'b0,
        addr: '0, wdata: '0
    };

    ctl_t          ctl_d, ctl_q;
    logic          tmr_load;
    logic [CW-1:0] tmr_val;
    logic          tmr_last;
    logic          cap_en;

    always_comb begin
        ctl_d    = ctl_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        cap_en   = 1'b0;
        unique case (ctl_q.state)
            ST_PWRUP: begin
                if (tmr_last) ctl_d.state = ST_IDLE;
            end
            ST_IDLE: begin
                if (req_valid) begin
                    ctl_d.addr = req_addr;
                    ctl_d.ce_n = 1'b0;
                    tmr_load   = 1'b1;
                    if (req_we) begin
                        ctl_d.wdata = req_wdata;
                        ctl_d.state = ST_WSET;
                        tmr_val     = '0;
                    end else begin
                        ctl_d.oe_n  = 1'b0;
                        ctl_d.state = ST_READ;
                        tmr_val     = CW'(AA_CYC - 1);
                    end
                end
            end
            ST_READ: begin
                if (tmr_last) begin
                    cap_en      = 1'b1;
                    ctl_d.ce_n  = 1'b1;
                    ctl_d.oe_n  = 1'b1;
                    ctl_d.state = ST_IDLE;
                end
            end
            ST_WSET: begin
                if (tmr_last) begin
                    ctl_d.we_n  = 1'b0;
                    ctl_d.state = ST_WTURN;
                    tmr_load    = 1'b1;
                    tmr_val     = CW'(HZ_CYC - 1);
                end
            end
            ST_WTURN: begin
                if (tmr_last) begin
                    ctl_d.dq_oe = 1'b1;
                    ctl_d.state = ST_WDATA;
                    tmr_load    = 1'b1;
                    tmr_val     = CW'(WD_CYC - 1);
                end
            end
            ST_WDATA: begin
                if (tmr_last) begin
                    ctl_d.we_n  = 1'b1;
                    ctl_d.ce_n  = 1'b1;
                    ctl_d.dq_oe = 1'b0;
                    ctl_d.state = ST_IDLE;
                end
            end
            default: ctl_d = CTL_RST;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= CTL_RST;
        else        ctl_q <= ctl_d;
    end

    sram_wait_timer #(
        .CW       (CW),
        .RST_LOAD (PWR_CYC - 1)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .last     (tmr_last)
    );

    sram_rd_capture #(
        .DW (DATA_W)
    ) u_capture (
        .clk    (clk),
        .rst_n  (rst_n),
        .cap_en (cap_en),
        .bus_in (mem_dq_in),
        .rdata  (rsp_rdata),
        .rvalid (rsp_valid)
    );

    assign req_ready  = (ctl_q.state == ST_IDLE);
    assign mem_ce_n   = ctl_q.ce_n;
    assign mem_oe_n   = ctl_q.oe_n;
    assign mem_we_n   = ctl_q.we_n;
    assign mem_addr   = ctl_q.addr;
    assign mem_dq_out = ctl_q.wdata;
    assign mem_dq_oe  = ctl_q.dq_oe;
endmodule

// File: rtl/sram_access_ctrl_chk.sv
module sram_access_ctrl_chk
    import sram_ctrl_pkg::*;
#(
    parameter int unsigned ADDR_W     = 19,
    parameter int unsigned DATA_W     = 8,
    parameter int unsigned CLK_PS     = 5000,
    parameter int unsigned T_PWRUP_PS = 1000000,
    parameter int unsigned T_AA_PS    = 10000,
    parameter int unsigned T_PWE_PS   = 7000,
    parameter int unsigned T_SD_PS    = 5000,
    parameter int unsigned T_HZWE_PS  = 5000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic              mem_ce_n,
    input logic              mem_oe_n,
    input logic              mem_we_n,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_dq_out,
    input logic              mem_dq_oe
);
    localparam int unsigned PWR_CYC = ps_to_cyc(T_PWRUP_PS, CLK_PS);
    localparam int unsigned AA_CYC  = ps_to_cyc(T_AA_PS, CLK_PS);
    localparam int unsigned PWE_CYC = ps_to_cyc(T_PWE_PS, CLK_PS);

    int unsigned pu_cnt, we_low_cnt, oe_low_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pu_cnt     <= 0;
            we_low_cnt <= 0;
            oe_low_cnt <= 0;
        end else begin
            if (pu_cnt < PWR_CYC) pu_cnt <= pu_cnt + 1;
            we_low_cnt <= mem_we_n ? 0 : we_low_cnt + 1;
            oe_low_cnt <= mem_oe_n ? 0 : oe_low_cnt + 1;
        end
    end

    assert_pwrup_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (pu_cnt < PWR_CYC) |-> (!req_ready && mem_ce_n && mem_we_n && !mem_dq_oe));

    assert_busy_not_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_ce_n |-> !req_ready);

    assert_read_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_oe_n) |-> (oe_low_cnt >= AA_CYC));

    assert_rsp_with_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $rose(mem_oe_n));

    assert_rsp_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    assert_addr_before_we_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_we_n) |-> ($past(!mem_ce_n) && mem_oe_n));

    assert_we_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (we_low_cnt >= PWE_CYC));

    assert_drive_in_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> (!mem_we_n && !mem_ce_n && mem_oe_n));

    assert_release_with_we_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> !mem_dq_oe);

    assert_wdata_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_dq_oe && $past(mem_dq_oe)) |-> $stable(mem_dq_out));

    assert_no_oe_we_overlap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_oe_n && !mem_we_n));

    assert_addr_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));
endmodule

bind sram_access_ctrl sram_access_ctrl_chk #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .CLK_PS     (CLK_PS),
    .T_PWRUP_PS (T_PWRUP_PS),
    .T_AA_PS    (T_AA_PS),
    .T_PWE_PS   (T_PWE_PS),
    .T_SD_PS    (T_SD_PS),
    .T_HZWE_PS  (T_HZWE_PS)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_ready  (req_ready),
    .rsp_valid  (rsp_valid),
    .mem_ce_n   (mem_ce_n),
    .mem_oe_n   (mem_oe_n),
    .mem_we_n   (mem_we_n),
    .mem_addr   (mem_addr),
    .mem_dq_out (mem_dq_out),
    .mem_dq_oe  (mem_dq_oe)
);

// File: tb/tb_sram_access_ctrl.sv
`timescale 1ns/1ps
module tb_sram_access_ctrl;
    localparam int AW = 8;
    localparam int DW = 8;
    localparam int DEPTH = 1 << AW;
    localparam int CLKP = 5000;
    localparam int TPWR = 1000000, TAA = 10000, TPWE = 7000, TSD = 5000, THZ = 5000;

    function automatic int cyc(input int t);
        int c;
        c = (t + CLKP - 1) / CLKP;
        return (c < 1) ? 1 : c;
    endfunction

    localparam int PWR_CYC = cyc(TPWR);
    localparam int AA_CYC  = cyc(TAA);
    localparam int PWE_CYC = cyc(TPWE);
    localparam int SD_CYC  = cyc(TSD);
    localparam int HZ_CYC  = cyc(THZ);

    logic clk = 0, rst_n = 0;
    logic req_valid = 0, req_we = 0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic req_ready, rsp_valid, mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
    logic [DW-1:0] rsp_rdata, mem_dq_out, mem_dq_in;
    logic [AW-1:0] mem_addr;

    always #2.5 clk = ~clk;

    sram_access_ctrl #(
        .ADDR_W(AW), .DATA_W(DW), .CLK_PS(CLKP), .T_PWRUP_PS(TPWR),
        .T_AA_PS(TAA), .T_PWE_PS(TPWE), .T_SD_PS(TSD), .T_HZWE_PS(THZ)
    ) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_ce_n(mem_ce_n),
        .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_addr(mem_addr),
        .mem_dq_out(mem_dq_out), .mem_dq_in(mem_dq_in), .mem_dq_oe(mem_dq_oe)
    );

    // memory model: truth-table driver, store at end of select/strobe overlap
    logic [DW-1:0] marr [DEPTH];
    logic [DW-1:0] shadow [DEPTH];
    logic [DW-1:0] wr_latch;
    logic mem_drv, wr_act, contention;
    assign mem_drv = !mem_ce_n && !mem_oe_n && mem_we_n;
    assign wr_act  = !mem_ce_n && !mem_we_n;
    assign mem_dq_in = mem_drv ? marr[mem_addr] : (mem_dq_oe ? mem_dq_out : 'z);

    initial contention = 0;
    always @(mem_drv or mem_dq_oe) if (mem_drv && mem_dq_oe) contention = 1;
    always @(wr_act or mem_dq_oe or mem_dq_out) if (wr_act && mem_dq_oe) wr_latch = mem_dq_out;
    always @(negedge wr_act) marr[mem_addr] = wr_latch;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // strobe-level monitor
    logic p_we_n = 1, p_oe_n = 1, p_ce_n = 1, p_dq_oe = 0;
    logic [AW-1:0] p_addr = '0;
    int we_run = 0, oe_run = 0, drv_run = 0;
    always @(negedge clk) if (rst_n) begin
        if (!mem_we_n && p_we_n)
            chk(!p_ce_n && mem_oe_n, "R5", "select/OE before strobe", {p_ce_n, mem_oe_n}, 1);
        if (mem_we_n && !p_we_n) begin
            chk(we_run >= PWE_CYC, "R5", "strobe width", we_run, PWE_CYC);
            chk(drv_run >= SD_CYC, "R7", "data setup", drv_run, SD_CYC);
            chk(!mem_dq_oe, "R6", "release with strobe", mem_dq_oe, 0);
        end
        if (mem_dq_oe && !p_dq_oe)
            chk(we_run == HZ_CYC, "R6", "drive onset", we_run, HZ_CYC);
        if (mem_oe_n && !p_oe_n)
            chk(oe_run == AA_CYC, "R3", "read width", oe_run, AA_CYC);
        if (!mem_oe_n)
            chk(mem_we_n && !mem_ce_n, "R3", "read strobes", {mem_we_n, mem_ce_n}, 2);
        if (!mem_ce_n && !p_ce_n)
            chk(mem_addr == p_addr, "R9", "address hold", mem_addr, p_addr);
        if (!mem_ce_n)
            chk(!req_ready, "R2", "ready while selected", req_ready, 0);
        we_run  = !mem_we_n ? we_run + 1 : 0;
        oe_run  = !mem_oe_n ? oe_run + 1 : 0;
        drv_run = mem_dq_oe ? drv_run + 1 : 0;
        p_we_n = mem_we_n; p_oe_n = mem_oe_n; p_ce_n = mem_ce_n;
        p_dq_oe = mem_dq_oe; p_addr = mem_addr;
    end

    task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
        while (!req_ready) @(negedge clk);
        req_valid = 1; req_we = 1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 0;
        chk(!req_ready, "R2", "ready after accept", req_ready, 0);
        shadow[a] = d;
    endtask

    task automatic do_read(input logic [AW-1:0] a);
        int n;
        while (!req_ready) @(negedge clk);
        req_valid = 1; req_we = 0; req_addr = a;
        @(negedge clk);
        req_valid = 0;
        n = 0;
        while (!rsp_valid) begin @(negedge clk); n++; end
        chk(n == AA_CYC, "R4", "response latency", n, AA_CYC);
        chk(rsp_rdata == shadow[a], "R4", $sformatf("read data @%0d", a), rsp_rdata, shadow[a]);
        chk(mem_ce_n && mem_oe_n, "R4", "strobes released at response", {mem_ce_n, mem_oe_n}, 3);
        @(negedge clk);
        chk(!rsp_valid, "R4", "response pulse width", rsp_valid, 0);
    endtask

    initial begin
        int n;
        repeat (3) @(negedge clk);
        chk(!req_ready && mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe, "R1",
            "reset state", {req_ready, mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe}, 14);
        rst_n = 1;
        n = 0;
        while (!req_ready) begin
            if (!mem_ce_n || !mem_we_n || mem_dq_oe) chk(0, "R1", "strobe during power-up", n, 0);
            @(negedge clk); n++;
        end
        chk(n == PWR_CYC, "R1", "power-up length", n, PWR_CYC);

        // full sweep: write every address, then read all back
        for (int a = 0; a < DEPTH; a++) do_write(AW'(a), DW'((a * 37 + 11) ^ (a >> 3)));
        for (int a = 0; a < DEPTH; a++) do_read(AW'(a));
        for (int a = 0; a < DEPTH; a++)
            chk(marr[a] == shadow[a], "R7", $sformatf("stored byte @%0d", a), marr[a], shadow[a]);

        // boundary patterns and random read-after-write
        do_write('0, 8'h00); do_read('0);
        do_write('1, 8'hFF); do_read('1);
        do_write(AW'(8'h55), 8'hAA); do_read(AW'(8'h55));
        for (int i = 0; i < 300; i++) begin
            logic [AW-1:0] ra;
            ra = AW'($urandom);
            do_write(ra, DW'($urandom));
            if (i % 3 == 0) do_read(AW'($urandom));
            do_read(ra);
        end

        chk(!contention, "R8", "bus contention", contention, 0);
        repeat (4) @(negedge clk);
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule